// File: doc/BRIEF.md
# General Purpose I/O Bank with Masked Output Writes

This block is one bank of general purpose I/O lines behind a small register bus. Software sets the output levels in one of two ways. A full-word write replaces every output bit. A masked write changes only the bits it selects in one half of the bank, so software never has to read, modify and write back the other bits. A direction register and a drive register together decide which bits have an active driver. A read-only register gives the input lines after a two-flop synchronizer.

One build parameter chooses what the bank drives. The pad variant feeds three-state pads, and a per-pin override input can force any pad off. The fabric variant feeds plain wires, where the enable output is only direction AND drive. A strap parameter can reserve two bits as outputs only. Those bits then always read as outputs in the direction register and read as zero in the sample register.

Register map, by word address on `bus_addr`: 0 output level (full word), 1 low-half masked write, 2 high-half masked write, 3 direction, 4 drive, 5 input sample (read-only). A masked write word carries an active-low select in bits [31:16] and the new data in bits [15:0].

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, `gpio_out`, `gpio_oe` and `bus_rdata` are zero, and the level, direction and drive registers read as zero (strap bits excepted, see R9).
- R2: A write to address 0 replaces all 32 bits of the output level with `bus_wdata`.
- R3: A write to address 1 sets level bit i (i in 0..15) to `bus_wdata[i]` only where `bus_wdata[16+i]` is 0. The other low bits and all of bits [31:16] keep their values.
- R4: A write to address 2 sets level bit 16+i to `bus_wdata[i]` only where `bus_wdata[16+i]` is 0. Bits [15:0] and the unselected high bits keep their values.
- R5: A read of address 0, 1 or 2 returns the current output level register, whatever the levels on `pin_in`. `bus_rdata` is registered: it is valid in the cycle after `bus_rd` and holds until the next read.
- R6: `gpio_out` equals the output level register delayed by one clock. It does not depend on the drive register or on `pad_tri_force`.
- R7: In the pad variant, `gpio_oe[x]` equals direction[x] AND drive[x] AND NOT `pad_tri_force[x]`, as sampled one clock earlier.
- R8: A read of address 5 returns `pin_in` after a two-flop synchronizer, whatever the direction and output settings. Writes to address 5 have no effect.
- R9: With the strap option on, bits 8 and 7 read as 1 in the direction register whatever was written, act as outputs for R7, and read as 0 in the sample register.
- R10: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Input lines from pads or fabric |
| pad_tri_force | input | 32 | Per-pin forced three-state (pad variant only) |
| gpio_out | output | 32 | Registered output levels |
| gpio_oe | output | 32 | Registered per-bit driver enables |

## Verification
The bench sends masked writes whose select words are sparse and irregular. A design that took the select as active-high, or that let a low-half write spill into the high half, would then corrupt exactly the bits that should hold. It drives `pin_in` with patterns that differ from the output level, so a readback that returned pin levels instead of the stored level would show up at once. It also raises the pad override while direction and drive are both set, which catches enable logic that ignores the override or applies it one cycle late. A run of strap checks covers bits 8 and 7: they must stay outputs after direction is cleared and must read as zero in the sample register while the pins are high.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // register word addresses
  localparam int unsigned ADDR_LEVEL     = 0;
  localparam int unsigned ADDR_LO_MASKED = 1;
  localparam int unsigned ADDR_HI_MASKED = 2;
  localparam int unsigned ADDR_DIR       = 3;
  localparam int unsigned ADDR_DRIVE     = 4;
  localparam int unsigned ADDR_SAMPLE    = 5;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int unsigned      WIDTH      = 32,
  parameter int unsigned      ADDR_W     = 3,
  parameter logic [WIDTH-1:0] STRAP_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  level_q,
  output logic [WIDTH-1:0]  dir_eff,
  output logic [WIDTH-1:0]  drive_q
);
  import gpio_bank_pkg::*;
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] level_nxt;
  logic [WIDTH-1:0] dir_q;

  always_comb begin
    level_nxt = level_q;
    if (wr) begin
      if (addr == ADDR_W'(ADDR_LEVEL)) begin
        level_nxt = wdata;
      end else if (addr == ADDR_W'(ADDR_LO_MASKED)) begin
        for (int i = 0; i < HALF; i++)
          if (!wdata[HALF+i]) level_nxt[i] = wdata[i];
      end else if (addr == ADDR_W'(ADDR_HI_MASKED)) begin
        for (int i = 0; i < HALF; i++)
          if (!wdata[HALF+i]) level_nxt[HALF+i] = wdata[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      dir_q   <= '0;
      drive_q <= '0;
    end else begin
      level_q <= level_nxt;
      if (wr && addr == ADDR_W'(ADDR_DIR))   dir_q   <= wdata;
      if (wr && addr == ADDR_W'(ADDR_DRIVE)) drive_q <= wdata;
    end
  end

  // strap bits are outputs regardless of what was written
  assign dir_eff = dir_q | STRAP_MASK;
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive #(
  parameter int unsigned WIDTH  = 32,
  parameter bit          FABRIC = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] dir_eff,
  input  logic [WIDTH-1:0] drive,
  input  logic [WIDTH-1:0] tri_force,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] oe_q
);
  logic [WIDTH-1:0] en;

  if (FABRIC) begin : g_fabric
    logic [WIDTH-1:0] unused_tri;
    assign unused_tri = tri_force;
    assign en = dir_eff & drive;
  end else begin : g_pad
    assign en = dir_eff & drive & ~tri_force;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= level;
      oe_q  <= en;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned SYNC_N   = 2,
  parameter bit          FABRIC   = 1'b0,
  parameter bit          STRAP_EN = 1'b1,
  parameter int unsigned STRAP_LO = 7,
  parameter int unsigned STRAP_HI = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  pad_tri_force,
  output logic [WIDTH-1:0]  gpio_out,
  output logic [WIDTH-1:0]  gpio_oe
);
  import gpio_bank_pkg::*;

  function automatic logic [WIDTH-1:0] make_strap();
    logic [WIDTH-1:0] m;
    m = '0;
    if (STRAP_EN)
      for (int i = 0; i < WIDTH; i++)
        if (i >= STRAP_LO && i <= STRAP_HI) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [WIDTH-1:0] STRAP_MASK = make_strap();

  logic [WIDTH-1:0] level_q, dir_eff, drive_q, sampled;

  gpio_bank_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .STRAP_MASK(STRAP_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .level_q(level_q), .dir_eff(dir_eff), .drive_q(drive_q)
  );

  gpio_bank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sampled)
  );

  gpio_bank_drive #(.WIDTH(WIDTH), .FABRIC(FABRIC)) u_drive (
    .clk(clk), .rst(rst), .level(level_q), .dir_eff(dir_eff), .drive(drive_q),
    .tri_force(pad_tri_force), .out_q(gpio_out), .oe_q(gpio_oe)
  );

  logic [WIDTH-1:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      ADDR_W'(ADDR_LEVEL),
      ADDR_W'(ADDR_LO_MASKED),
      ADDR_W'(ADDR_HI_MASKED): rd_mux = level_q;
      ADDR_W'(ADDR_DIR):       rd_mux = dir_eff;
      ADDR_W'(ADDR_DRIVE):     rd_mux = drive_q;
      ADDR_W'(ADDR_SAMPLE):    rd_mux = sampled & ~STRAP_MASK;
      default:                 rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned      WIDTH      = 32,
  parameter int unsigned      ADDR_W     = 3,
  parameter bit               FABRIC     = 1'b0,
  parameter logic [WIDTH-1:0] STRAP_MASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_tri_force,
  input logic [WIDTH-1:0]  gpio_out,
  input logic [WIDTH-1:0]  gpio_oe,
  input logic [WIDTH-1:0]  level_q
);
  import gpio_bank_pkg::*;
  localparam int unsigned HALF = WIDTH / 2;

  assert_full_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADDR_LEVEL)) |=> level_q == $past(bus_wdata));

  assert_lo_keeps_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADDR_LO_MASKED)) |=> level_q[WIDTH-1:HALF] == $past(level_q[WIDTH-1:HALF]));

  assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADDR_HI_MASKED)) |=> level_q[HALF-1:0] == $past(level_q[HALF-1:0]));

  assert_out_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> gpio_out == $past(level_q));

  assert_tri_override_R7: assert property (@(posedge clk) disable iff (rst)
    (!FABRIC && !$past(rst)) |-> (gpio_oe & $past(pad_tri_force)) == '0);

  assert_strap_sample_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(ADDR_SAMPLE)) |=> (bus_rdata & STRAP_MASK) == '0);

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr > ADDR_W'(ADDR_SAMPLE)) |=> $stable(level_q));
endmodule

bind gpio_bank gpio_bank_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .FABRIC(FABRIC), .STRAP_MASK(STRAP_MASK)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_tri_force(pad_tri_force),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe), .level_q(level_q)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0, pad_tri_force = '0;
  logic [31:0] bus_rdata, gpio_out, gpio_oe;

  int total = 0, bad = 0;
  localparam logic [31:0] STRAP = 32'h0000_0180;

  always #2.5 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_tri_force(pad_tri_force), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  // behavioural reference model, advanced on every rising edge
  logic [31:0] m_level, m_dir, m_drive, m_s1, m_s2, e_out, e_oe, e_rd;
  always @(posedge clk) begin
    if (rst) begin
      m_level <= '0; m_dir <= '0; m_drive <= '0; m_s1 <= '0; m_s2 <= '0;
      e_out <= '0; e_oe <= '0; e_rd <= '0;
    end else begin
      logic [31:0] nl;
      e_out <= m_level;
      e_oe  <= (m_dir | STRAP) & m_drive & ~pad_tri_force;
      m_s1  <= pin_in;
      m_s2  <= m_s1;
      if (bus_rd) begin
        if (bus_addr <= 3'd2)      e_rd <= m_level;
        else if (bus_addr == 3'd3) e_rd <= m_dir | STRAP;
        else if (bus_addr == 3'd4) e_rd <= m_drive;
        else if (bus_addr == 3'd5) e_rd <= m_s2 & ~STRAP;
        else                       e_rd <= '0;
      end
      if (bus_wr) begin
        nl = m_level;
        if (bus_addr == 3'd0) nl = bus_wdata;
        for (int i = 0; i < 16; i++) begin
          if (bus_addr == 3'd1 && !bus_wdata[16+i]) nl[i] = bus_wdata[i];
          if (bus_addr == 3'd2 && !bus_wdata[16+i]) nl[16+i] = bus_wdata[i];
        end
        m_level <= nl;
        if (bus_addr == 3'd3) m_dir   <= bus_wdata;
        if (bus_addr == 3'd4) m_drive <= bus_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 model gpio_out", gpio_out, e_out);
      chk("R7 model gpio_oe", gpio_oe, e_oe);
      chk("R5 model bus_rdata", bus_rdata, e_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 out after reset", gpio_out, 32'h0);
    chk("R1 oe after reset", gpio_oe, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd(3'd0, v); chk("R1 level reads zero", v, 32'h0);
    rd(3'd4, v); chk("R1 drive reads zero", v, 32'h0);
    rd(3'd3, v); chk("R9 strap dir after reset", v, STRAP);

    wr(3'd0, 32'hA5A5_1234);
    rd(3'd0, v); chk("R2 full write", v, 32'hA5A5_1234);
    chk("R6 gpio_out after full write", gpio_out, 32'hA5A5_1234);

    wr(3'd1, 32'hFF00_5A3C);
    rd(3'd1, v); chk("R3 low masked write", v, 32'hA5A5_123C);
    wr(3'd2, 32'h0F0F_BEEF);
    rd(3'd2, v); chk("R4 high masked write", v, 32'hB5E5_123C);
    wr(3'd1, 32'hFFFF_0000);
    rd(3'd0, v); chk("R3 empty select no change", v, 32'hB5E5_123C);

    pin_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R5 readback not pin level", v, 32'hB5E5_123C);
    rd(3'd5, v); chk("R8 sample with strap bits zero R9", v, 32'hFFFF_FE7F);
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R8 write to sample ignored", v, 32'hFFFF_FE7F);

    pad_tri_force = 32'h0000_0030;
    wr(3'd3, 32'h0000_FFFF);
    wr(3'd4, 32'h00FF_00F0);
    @(negedge clk);
    chk("R7 enable with override", gpio_oe, 32'h0000_00C0);
    pad_tri_force = 32'h0;
    @(negedge clk);
    chk("R7 override released", gpio_oe, 32'h0000_00F0);
    chk("R6 out ignores drive", gpio_out, 32'hB5E5_123C);

    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0000_0180);
    @(negedge clk);
    chk("R9 strap bits stay outputs", gpio_oe, 32'h0000_0180);
    rd(3'd3, v); chk("R9 dir readback forced", v, STRAP);

    pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R8 sample second pattern", v, 32'h1234_5678 & ~STRAP);

    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R10 unmapped read zero", v, 32'h0);
    rd(3'd0, v); chk("R10 unmapped write no effect", v, 32'hB5E5_123C);
    rd(3'd4, v); chk("R10 drive unchanged", v, 32'h0000_0180);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule